// File: doc/BRIEF.md
# Interrupt Vector Aggregation Controller

This block gathers up to 256 edge-type interrupt vectors into eight groups of 32 and drives one parent interrupt line per group. An upstream unit reports each event as a one-cycle strobe carrying an 8-bit vector number. Vector `n` belongs to group `n / 32` and sits at bit `n % 32` in that group's registers. Each event sets a latched cause bit, and the bit stays set until software clears it.

Software reaches the block through a plain 32-bit register port with a byte address. It reads the latched causes and clears them by writing ones. It reads and writes a separate bank of enable words that decide which latched causes may raise the group's parent line. Enable words keep their values until they are rewritten, so software can save the whole bank and restore it later. Reads of the register port are combinational from the address. A write takes effect at the rising clock edge on which `reg_wr_en` is high.

Top module: `irq_vec_agg`

## Requirements
- R1: After a synchronous reset, every cause bit and every enable bit is 0, and every parent line is low.
- R2: A cycle with `vec_set_valid` high and vector number n sets cause bit n%32 of group n/32. The bit reads back as 1 from the cycle after that edge on.
- R3: A cause bit latches whatever its enable bit holds, and a cause read returns the raw latched bits, masked bits included.
- R4: A write to the cause word of group i (byte offset 4*i) clears every cause bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0xFFFFFFFF empties the group. Cause bits never clear in any other way.
- R5: The enable word of group i (byte offset 0x20 + 4*i) reads back exactly the last value written to it. An enable word changes only when a write is made to its own offset.
- R6: Parent line i is high exactly while group i has a cause bit whose enable bit is 1 (1 = unmasked, 0 = masked). A line can rise only after an edge that carried a vector event or a register write.
- R7: When a vector event and a one-bit clear hit the same cause bit on the same edge, the bit ends up set.
- R8: An address with nonzero low two bits, or a word offset of 0x40 or above, reads as 0. Writes to such an address change no cause or enable bit.
- R9: A write to an enable word leaves all cause bits untouched, and a write to a cause word leaves all enable bits untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_set_valid | input | 1 | One-cycle strobe reporting a vector event |
| vec_set_num | input | 8 | Number of the vector that fired |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 8 | Parent interrupt line, one per group |

## Verification
The hardest case to reach is a vector event and a software clear landing on the same cause bit on the same clock edge. The bench builds this case directly: it drives the strobe and a cause-word write whose data covers that bit in one cycle, then reads the word back. A randomized phase adds frequent overlaps of sets, clears and enable writes inside one small group range, so that collisions of this kind and mask changes on pending bits happen many times. The bench model is compared with the parent lines on every cycle.

// File: rtl/ivec_pkg.sv
// Package: constants and the decoded register-select type shared by the
// interrupt vector aggregation blocks. Assumes at most eight groups.
package ivec_pkg;
    localparam int MAX_GROUPS   = 8;
    localparam int GRP_IDX_W    = $clog2(MAX_GROUPS);
    localparam int EN_BASE_WORD = 8;   // enable bank starts at byte 0x20

    typedef struct packed {
        logic                 is_cause;
        logic                 is_en;
        logic [GRP_IDX_W-1:0] grp;
    } reg_sel_t;
endpackage

// File: rtl/ivec_addr_dec.sv
// Address decoder: classifies a byte address as a cause word, an enable word,
// or unimplemented, and extracts the group index. Assumes word-aligned access;
// anything else counts as unimplemented.
module ivec_addr_dec
    import ivec_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    // Purpose: map the word index onto a bank and a group number.
    always_comb begin
        sel = '0;
        if (aligned && (int'(word_idx) < NUM_GROUPS)) begin
            sel.is_cause = 1'b1;
            sel.grp      = GRP_IDX_W'(word_idx);
        end else if (aligned && (int'(word_idx) >= EN_BASE_WORD) &&
                     (int'(word_idx) < EN_BASE_WORD + NUM_GROUPS)) begin
            sel.is_en = 1'b1;
            sel.grp   = GRP_IDX_W'(int'(word_idx) - EN_BASE_WORD);
        end
    end
endmodule

// File: rtl/ivec_set_dec.sv
// Event decoder: turns a vector strobe plus number into a one-hot set mask
// over all vectors. Numbers beyond the implemented groups are dropped.
module ivec_set_dec #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 32,
    parameter int VEC_W      = 8
) (
    input  logic                             valid,
    input  logic [VEC_W-1:0]                 num,
    output logic [NUM_GROUPS*GROUP_BITS-1:0] set_mask
);
    localparam int BIT_W = $clog2(GROUP_BITS);

    int unsigned         grp_idx;
    logic [BIT_W-1:0]    bit_idx;

    assign grp_idx = int'(num) / GROUP_BITS;
    assign bit_idx = BIT_W'(int'(num) % GROUP_BITS);

    // Purpose: one decoded slice per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
        assign set_mask[g*GROUP_BITS +: GROUP_BITS] =
            (valid && (grp_idx == g)) ? (GROUP_BITS'(1) << bit_idx) : '0;
    end
endmodule

// File: rtl/ivec_group.sv
// One vector group: latched cause word (set by events, cleared by writing
// ones), enable word, and the group's parent line. An event beats a clear
// on the same bit in the same cycle.
module ivec_group #(
    parameter int GROUP_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_BITS-1:0] set_bits,
    input  logic                  cause_wr,
    input  logic                  en_wr,
    input  logic [GROUP_BITS-1:0] wdata,
    output logic [GROUP_BITS-1:0] cause,
    output logic [GROUP_BITS-1:0] enable,
    output logic                  irq
);
    logic [GROUP_BITS-1:0] clr_bits;

    assign clr_bits = cause_wr ? wdata : '0;

    // Purpose: hold latched causes; sets are ORed in after the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~clr_bits) | set_bits;
    end

    // Purpose: hold the mask word until software rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= wdata;
    end

    // Purpose: parent line follows any unmasked pending cause.
    assign irq = |(cause & enable);
endmodule

// File: rtl/irq_vec_agg.sv
// Top: interrupt vector aggregation controller. Decodes events and register
// accesses, instantiates one group per parent line, and muxes read data.
// Assumes GROUP_BITS equals the 32-bit register data width.
module irq_vec_agg
    import ivec_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 32,
    parameter int ADDR_W     = 8,
    parameter int VEC_W      = $clog2(NUM_GROUPS * GROUP_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vec_set_valid,
    input  logic [VEC_W-1:0]      vec_set_num,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [GROUP_BITS-1:0] reg_wdata,
    output logic [GROUP_BITS-1:0] reg_rdata,
    output logic [NUM_GROUPS-1:0] irq_out
);
    localparam int NUM_VEC = NUM_GROUPS * GROUP_BITS;

    reg_sel_t              sel;
    logic [NUM_VEC-1:0]    set_mask;
    logic [NUM_VEC-1:0]    cause_flat;
    logic [NUM_VEC-1:0]    en_flat;

    ivec_addr_dec #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_addr_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    ivec_set_dec #(.NUM_GROUPS(NUM_GROUPS), .GROUP_BITS(GROUP_BITS),
                   .VEC_W(VEC_W)) u_set_dec (
        .valid    (vec_set_valid),
        .num      (vec_set_num),
        .set_mask (set_mask)
    );

    // Purpose: one register group and parent line per group index.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = (int'(sel.grp) == g);
        ivec_group #(.GROUP_BITS(GROUP_BITS)) u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_mask[g*GROUP_BITS +: GROUP_BITS]),
            .cause_wr (reg_wr_en && sel.is_cause && hit),
            .en_wr    (reg_wr_en && sel.is_en && hit),
            .wdata    (reg_wdata),
            .cause    (cause_flat[g*GROUP_BITS +: GROUP_BITS]),
            .enable   (en_flat[g*GROUP_BITS +: GROUP_BITS]),
            .irq      (irq_out[g])
        );
    end

    // Purpose: return the addressed word, zero for unimplemented offsets.
    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(sel.grp) == g) begin
                if (sel.is_cause) reg_rdata = cause_flat[g*GROUP_BITS +: GROUP_BITS];
                if (sel.is_en)    reg_rdata = en_flat[g*GROUP_BITS +: GROUP_BITS];
            end
        end
    end
endmodule

// File: rtl/ivec_checker.sv
// Checker: temporal properties of the aggregation controller, bound to the
// top. Keeps one-cycle copies of inputs and state to compare edges.
module ivec_checker #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 32,
    parameter int ADDR_W     = 8,
    parameter int VEC_W      = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             vec_set_valid,
    input logic [VEC_W-1:0]                 vec_set_num,
    input logic                             reg_wr_en,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic [NUM_GROUPS-1:0]            irq_out,
    input logic [NUM_GROUPS*GROUP_BITS-1:0] cause_flat,
    input logic [NUM_GROUPS*GROUP_BITS-1:0] en_flat
);
    localparam int NUM_VEC = NUM_GROUPS * GROUP_BITS;

    logic                  prev_v;
    logic [VEC_W-1:0]      prev_n;
    logic                  prev_wr;
    logic                  prev_bad_wr;
    logic [NUM_GROUPS-1:0] prev_irq;
    logic [NUM_VEC-1:0]    prev_cause;
    logic [NUM_VEC-1:0]    prev_en;

    // Purpose: one-cycle history used by the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v      <= 1'b0;
            prev_n      <= '0;
            prev_wr     <= 1'b0;
            prev_bad_wr <= 1'b0;
            prev_irq    <= '0;
            prev_cause  <= '0;
            prev_en     <= '0;
        end else begin
            prev_v      <= vec_set_valid && (int'(vec_set_num) < NUM_VEC);
            prev_n      <= vec_set_num;
            prev_wr     <= reg_wr_en;
            prev_bad_wr <= reg_wr_en && ((reg_addr[1:0] != 2'b00) ||
                                         (int'(reg_addr) >= 'h40));
            prev_irq    <= irq_out;
            prev_cause  <= cause_flat;
            prev_en     <= en_flat;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (cause_flat == '0 && en_flat == '0 && irq_out == '0));

    // Also covers R7: the bit is set even if a clear hit it on that edge.
    assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prev_v |-> cause_flat[prev_n]);

    assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_cause & ~cause_flat) != '0) |-> prev_wr);

    assert_enable_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_wr |-> (en_flat == prev_en));

    assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~prev_irq) != '0) |-> (prev_v || prev_wr));

    assert_bad_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prev_bad_wr |-> (en_flat == prev_en && (prev_cause & ~cause_flat) == '0));
endmodule

bind irq_vec_agg ivec_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_BITS (GROUP_BITS),
    .ADDR_W     (ADDR_W),
    .VEC_W      (VEC_W)
) u_ivec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .vec_set_valid (vec_set_valid),
    .vec_set_num   (vec_set_num),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .irq_out       (irq_out),
    .cause_flat    (cause_flat),
    .en_flat       (en_flat)
);

// File: tb/tb_irq_vec_agg.sv
module tb_irq_vec_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_set_valid = 1'b0;
    logic [7:0]  vec_set_num = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    bit [31:0] m_cause [8];
    bit [31:0] m_en    [8];

    always #2 clk = ~clk;   // 250 MHz

    irq_vec_agg dut (
        .clk(clk), .rst_n(rst_n), .vec_set_valid(vec_set_valid),
        .vec_set_num(vec_set_num), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic bit [31:0] m_read(bit [7:0] a);
        int w = int'(a >> 2);
        if (a[1:0] != 2'b00) return 32'h0;
        if (w < 8) return m_cause[w];
        if (w >= 8 && w < 16) return m_en[w-8];
        return 32'h0;
    endfunction

    function automatic bit [7:0] m_irq();
        bit [7:0] r = '0;
        for (int g = 0; g < 8; g++) r[g] = |(m_cause[g] & m_en[g]);
        return r;
    endfunction

    task automatic check(string req, string what, bit [31:0] act, bit [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare lines.
    task automatic cycle(bit sv, bit [7:0] sn, bit wr, bit [7:0] a, bit [31:0] d);
        int w;
        vec_set_valid = sv; vec_set_num = sn;
        reg_wr_en = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        w = int'(a >> 2);
        if (wr && a[1:0] == 2'b00 && w < 8) m_cause[w] &= ~d;
        if (wr && a[1:0] == 2'b00 && w >= 8 && w < 16) m_en[w-8] = d;
        if (sv) m_cause[sn / 32][sn % 32] = 1'b1;
        @(negedge clk);
        vec_set_valid = 1'b0; reg_wr_en = 1'b0;
        check("R6", "parent lines", 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic rd(string req, bit [7:0] a);
        vec_set_valid = 1'b0; reg_wr_en = 1'b0; reg_addr = a;
        #1;
        check(req, $sformatf("read @%02h", a), reg_rdata, m_read(a));
        @(negedge clk);
        check("R6", "parent lines idle", 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic rd_all(string req);
        for (int i = 0; i < 16; i++) rd(req, 8'(i * 4));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 8; g++) begin m_cause[g] = '0; m_en[g] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "lines after reset", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        rd_all("R1");

        // R2: events at group edges and the middle
        cycle(1, 8'd0,   0, 8'h00, 0);
        cycle(1, 8'd31,  0, 8'h00, 0);
        cycle(1, 8'd32,  0, 8'h00, 0);
        cycle(1, 8'd100, 0, 8'h00, 0);
        cycle(1, 8'd255, 0, 8'h00, 0);
        rd("R2", 8'h00); rd("R2", 8'h04); rd("R2", 8'h0C); rd("R2", 8'h1C);

        // R3: masked causes still latched, lines low
        rd("R3", 8'h00);
        check("R3", "masked lines low", 32'(irq_out), 32'h0);

        // R5 / R9: enable writes read back, causes untouched
        cycle(0, 0, 1, 8'h20, 32'h8000_0001);
        cycle(0, 0, 1, 8'h3C, 32'h5A5A_A5A5);
        rd("R5", 8'h20); rd("R5", 8'h3C); rd("R9", 8'h00); rd("R9", 8'h1C);

        // R6: unmask pending -> line; mask -> drop
        check("R6", "group0 line", 32'(irq_out[0]), 32'h1);
        cycle(0, 0, 1, 8'h20, 32'h0);
        check("R6", "group0 masked", 32'(irq_out[0]), 32'h0);
        cycle(0, 0, 1, 8'h3C, 32'h8000_0000);
        check("R6", "group7 line", 32'(irq_out[7]), 32'h1);

        // R4: partial clear, then full clear; R9 enables survive
        cycle(0, 0, 1, 8'h00, 32'h0000_0001);
        rd("R4", 8'h00);
        cycle(0, 0, 1, 8'h1C, 32'hFFFF_FFFF);
        rd("R4", 8'h1C); rd("R9", 8'h3C);
        check("R4", "group7 line after clear", 32'(irq_out[7]), 32'h0);

        // R7: set and clear same bit on the same edge
        cycle(1, 8'd40, 0, 8'h00, 0);
        cycle(1, 8'd40, 1, 8'h04, 32'h0000_0100);
        rd("R7", 8'h04);
        check("R7", "bit 40 kept", reg_rdata & 32'h100, 32'h100);

        // R8: unimplemented offsets
        cycle(0, 0, 1, 8'h40, 32'hFFFF_FFFF);
        cycle(0, 0, 1, 8'h22, 32'hFFFF_FFFF);
        cycle(0, 0, 1, 8'h01, 32'hFFFF_FFFF);
        cycle(0, 0, 1, 8'hFC, 32'hFFFF_FFFF);
        rd("R8", 8'h40); rd("R8", 8'h22); rd("R8", 8'hFC); rd("R8", 8'h05);
        rd_all("R8");

        // Randomized mix focused on groups 1 and 2 (vectors 32..95)
        for (int k = 0; k < 600; k++) begin
            bit [7:0]  a;
            bit [31:0] d = $urandom;
            bit [7:0]  n = 8'(32 + ($urandom % 64));
            case ($urandom % 4)
                0: a = 8'h04;
                1: a = 8'h08;
                2: a = 8'h24;
                default: a = 8'h28;
            endcase
            cycle(($urandom % 2) == 0, n, ($urandom % 3) == 0, a, d);
            if (k % 8 == 0) rd("R7", a);
        end
        rd_all("R5");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule